// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo PCM stream made of a bit clock, a frame clock and a serial data line. It oversamples all three in a much faster system clock domain and acts on each detected rising edge of the bit clock. For every stereo frame it produces one 24-bit two's-complement word per channel, together with a single-cycle valid pulse.

A 3-bit selector picks the framing: 24-bit left-justified, 24-bit I2S, or right-justified with a 16-, 20- or 24-bit word. All five framings share one shift engine. Right-justified words end on the last bit clock of their half-frame. Words shorter than 24 bits come out left-aligned with zeros in the low bits. The selector is sampled only while reset is held, so a stream format stays fixed between resets.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is held and after it is released, `left_word` and `right_word` are zero and `frame_valid` is low until the first complete frame has arrived.
- R2: Format code 010 (24-bit left-justified): the MSB is the bit sampled on the first bit-clock rise after a frame-clock edge. The next 23 bits follow MSB first. The left channel is the half where the frame clock is high. Bits after the 24th in a half are ignored.
- R3: Format code 011 (24-bit I2S): the MSB is sampled on the second bit-clock rise after a frame-clock edge, and the left channel is the half where the frame clock is low. With 24 bit clocks per half, the LSB falls on the first bit of the following half and is still captured.
- R4: Format code 100 (24-bit right-justified): the word is the last 24 bits of each half-frame. Earlier bits in that half are ignored.
- R5: Format code 001 (20-bit right-justified): the last 20 bits of each half form output bits [23:4], and bits [3:0] are zero.
- R6: Format code 000 (16-bit right-justified): the last 16 bits of each half form output bits [23:8], and bits [7:0] are zero.
- R7: Format codes 101, 110 and 111 behave exactly like code 010.
- R8: `frame_valid` is a one-cycle pulse, issued once per frame after the right half completes. `left_word` and `right_word` change only in a cycle where `frame_valid` is high.
- R9: Frames of 32 bit clocks (16-bit mode), 40 (20-bit mode), 48 (24-bit modes) and 64 (all modes) are all received correctly.
- R10: After reset, a partial half-frame is discarded and no valid pulse is issued until a full left half and a full right half have been seen. From then on, exactly one pulse is issued per frame.
- R11: A change of `fmt_sel` while reset is low has no effect on how the stream is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset; also loads the format |
| fmt_sel | input | 3 | Stream format code, taken while reset is high |
| bck_in | input | 1 | Serial bit clock |
| frm_in | input | 1 | Frame (channel) clock |
| sdata_in | input | 1 | Serial data, MSB first |
| left_word | output | 24 | Left channel word, two's complement |
| right_word | output | 24 | Right channel word, two's complement |
| frame_valid | output | 1 | One-cycle pulse when a new word pair is published |

## Verification
Several properties are checked on every cycle:
- detected bit-clock events are never adjacent;
- the valid pulse lasts one cycle;
- the output words hold still between pulses;
- no pulse appears before a full half-frame has armed the receiver;
- the zero padding of the 16- and 20-bit right-justified modes is always present.

Whether the correct bits land in the correct channel needs the bench's streams. These cover each framing at its minimum and at 64 bit clocks per frame, the one-bit I2S delay that spills the LSB into the next half, junk bits outside the word, the alias codes, and a format change without reset.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int WORD_W = 24;
  localparam int RJ16_W = 16;
  localparam int RJ20_W = 20;

  typedef enum logic [2:0] {
    FMT_RJ16  = 3'b000,
    FMT_RJ20  = 3'b001,
    FMT_LJ24  = 3'b010,
    FMT_I2S24 = 3'b011,
    FMT_RJ24  = 3'b100
  } fmt_e;

  function automatic fmt_e decode_fmt(input logic [2:0] code);
    case (code)
      3'b000:  return FMT_RJ16;
      3'b001:  return FMT_RJ20;
      3'b011:  return FMT_I2S24;
      3'b100:  return FMT_RJ24;
      default: return FMT_LJ24;
    endcase
  endfunction

  function automatic logic is_rj(input fmt_e f);
    return (f == FMT_RJ16) || (f == FMT_RJ20) || (f == FMT_RJ24);
  endfunction

  function automatic logic [WORD_W-1:0] align_word(input fmt_e f, input logic [WORD_W-1:0] sh);
    case (f)
      FMT_RJ16: return {sh[RJ16_W-1:0], {(WORD_W-RJ16_W){1'b0}}};
      FMT_RJ20: return {sh[RJ20_W-1:0], {(WORD_W-RJ20_W){1'b0}}};
      default:  return sh;
    endcase
  endfunction
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bck_in,
  input  logic frm_in,
  input  logic sdata_in,
  output logic bit_evt,
  output logic frm_s,
  output logic sd_s
);
  logic [STAGES:0]   bck_p;
  logic [STAGES-1:0] frm_p;
  logic [STAGES-1:0] sd_p;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          bck_p <= '0;
          frm_p <= '0;
          sd_p  <= '0;
        end else begin
          bck_p <= {bck_p[0], bck_in};
          frm_p <= frm_in;
          sd_p  <= sdata_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          bck_p <= '0;
          frm_p <= '0;
          sd_p  <= '0;
        end else begin
          bck_p <= {bck_p[STAGES-1:0], bck_in};
          frm_p <= {frm_p[STAGES-2:0], frm_in};
          sd_p  <= {sd_p[STAGES-2:0], sdata_in};
        end
      end
    end
  endgenerate

  // Data and frame clock pass through the same depth as the bit clock,
  // so at a detected rise they hold the values present before the edge.
  assign bit_evt = bck_p[STAGES-1] & ~bck_p[STAGES];
  assign frm_s   = frm_p[STAGES-1];
  assign sd_s    = sd_p[STAGES-1];

  assert_evt_gap_R9: assert property (@(posedge clk) disable iff (rst)
    bit_evt |=> !bit_evt);
endmodule

// File: rtl/pcm_half_framer.sv
module pcm_half_framer #(
  parameter int MAX_HALF = 64,
  localparam int CNT_W = $clog2(MAX_HALF + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_evt,
  input  logic             frm_s,
  input  logic             delay_one,
  output logic             boundary,
  output logic [CNT_W-1:0] idx,
  output logic             ended_level
);
  logic             prev_frm;
  logic             prev_eff;
  logic [CNT_W-1:0] cnt;
  logic             eff;
  logic [CNT_W-1:0] cnt_next;

  // For the delayed framing, the frame level seen one bit earlier marks the
  // half, which puts the MSB at index 0 and lets the LSB spill over.
  assign eff      = delay_one ? prev_frm : frm_s;
  assign boundary = bit_evt && (eff != prev_eff);
  assign cnt_next = (cnt == CNT_W'(MAX_HALF - 1)) ? cnt : cnt + 1'b1;
  assign idx      = boundary ? '0 : cnt_next;
  assign ended_level = prev_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_frm <= 1'b0;
      prev_eff <= 1'b0;
      cnt      <= '0;
    end else if (bit_evt) begin
      prev_frm <= frm_s;
      prev_eff <= eff;
      cnt      <= idx;
    end
  end

  assert_idx_range_R9: assert property (@(posedge clk) disable iff (rst)
    bit_evt |-> (idx < CNT_W'(MAX_HALF)));
endmodule

// File: rtl/pcm_word_shifter.sv
module pcm_word_shifter
  import pcm_rx_pkg::*;
#(
  parameter int MAX_HALF = 64,
  localparam int CNT_W = $clog2(MAX_HALF + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_evt,
  input  logic [CNT_W-1:0]  idx,
  input  logic              sd_s,
  input  fmt_e              fmt,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] sh;
  logic              take;

  // Right-justified framings shift every bit and keep the newest ones;
  // the others stop once a full word has been taken.
  assign take = is_rj(fmt) || (idx < CNT_W'(WORD_W));
  assign word = align_word(fmt, sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else if (bit_evt && take) begin
      sh <= {sh[WORD_W-2:0], sd_s};
    end
  end
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_HALF    = 64,
  localparam int CNT_W = $clog2(MAX_HALF + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        fmt_sel,
  input  logic              bck_in,
  input  logic              frm_in,
  input  logic              sdata_in,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word,
  output logic              frame_valid
);
  fmt_e              cfg;
  logic              bit_evt, frm_s, sd_s;
  logic              boundary, ended_level, ended_left, delay_one;
  logic [CNT_W-1:0]  idx;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] left_stage;
  logic              armed, have_left;

  always_ff @(posedge clk) begin
    if (rst) cfg <= decode_fmt(fmt_sel);
  end

  assign delay_one  = (cfg == FMT_I2S24);
  assign ended_left = delay_one ? ~ended_level : ended_level;

  pcm_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bck_in(bck_in), .frm_in(frm_in), .sdata_in(sdata_in),
    .bit_evt(bit_evt), .frm_s(frm_s), .sd_s(sd_s)
  );

  pcm_half_framer #(.MAX_HALF(MAX_HALF)) u_framer (
    .clk(clk), .rst(rst), .bit_evt(bit_evt), .frm_s(frm_s), .delay_one(delay_one),
    .boundary(boundary), .idx(idx), .ended_level(ended_level)
  );

  pcm_word_shifter #(.MAX_HALF(MAX_HALF)) u_shift (
    .clk(clk), .rst(rst), .bit_evt(bit_evt), .idx(idx), .sd_s(sd_s), .fmt(cfg),
    .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed       <= 1'b0;
      have_left   <= 1'b0;
      left_stage  <= '0;
      left_word   <= '0;
      right_word  <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (boundary) begin
        if (!armed) begin
          armed <= 1'b1;
        end else if (ended_left) begin
          left_stage <= word;
          have_left  <= 1'b1;
        end else if (have_left) begin
          left_word   <= left_stage;
          right_word  <= word;
          frame_valid <= 1'b1;
          have_left   <= 1'b0;
        end
      end
    end
  end

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);
  assert_left_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> $stable(left_word));
  assert_right_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> $stable(right_word));
  assert_unarmed_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !frame_valid);
  assert_pad16_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && cfg == FMT_RJ16) |-> (left_word[7:0] == 8'h00 && right_word[7:0] == 8'h00));
  assert_pad20_R5: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && cfg == FMT_RJ20) |-> (left_word[3:0] == 4'h0 && right_word[3:0] == 4'h0));
endmodule

// File: tb/sim_pcm_serial_rx.sv
module sim_pcm_serial_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  fmt_sel = 3'b010;
  logic        bck_in = 1'b0, frm_in = 1'b0, sdata_in = 1'b0;
  logic [23:0] left_word, right_word;
  logic        frame_valid;

  int checks = 0, errors = 0, vcount = 0, cycles = 0;
  string cur_req = "R1";
  logic [23:0] exp_l[$], exp_r[$];
  bit lvl_q[$], dat_q[$];

  always #2.5 clk = ~clk;

  pcm_serial_rx u0 (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .bck_in(bck_in), .frm_in(frm_in),
    .sdata_in(sdata_in), .left_word(left_word), .right_word(right_word),
    .frame_valid(frame_valid)
  );

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (!rst && frame_valid) begin
      vcount++;
      if (exp_l.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s actual=extra_pulse expected=none", cur_req);
      end else begin
        chk(cur_req, left_word, exp_l.pop_front());
        chk(cur_req, right_word, exp_r.pop_front());
      end
    end
  end

  // Requirement R7 mapping of codes to framings: 0=RJ16 1=RJ20 3=I2S 4=RJ24 else LJ24.
  function automatic int mode_of(input logic [2:0] c);
    if (c == 3'd0 || c == 3'd1 || c == 3'd3 || c == 3'd4) return int'(c);
    return 2;
  endfunction

  function automatic int rj_len(input int m);
    return (m == 0) ? 16 : (m == 1) ? 20 : (m == 4) ? 24 : 0;
  endfunction

  function automatic logic [23:0] expect_of(input logic [23:0] w, input int m);
    if (m == 0) return {w[15:0], 8'h00};
    if (m == 1) return {w[19:0], 4'h0};
    return w;
  endfunction

  task automatic add_half(input bit lvl, input logic [23:0] w, input int m, input int h);
    int n;
    n = rj_len(m);
    for (int i = 0; i < h; i++) begin
      bit d;
      d = 1'($urandom);
      if (n == 0 && i < 24) d = w[23-i];
      if (n != 0 && i >= h - n) d = w[h-1-i];
      lvl_q.push_back(lvl);
      dat_q.push_back(d);
    end
  endtask

  task automatic run_case(input logic [2:0] code, input logic [2:0] later_code,
                          input int h, input int nfr, input string req);
    int m;
    bit i2s, left_lvl;
    m = mode_of(code);
    i2s = (m == 3);
    left_lvl = i2s ? 1'b0 : 1'b1;
    lvl_q.delete(); dat_q.delete();
    @(negedge clk);
    rst = 1'b1; fmt_sel = code; bck_in = 1'b0;
    frm_in = i2s ? 1'b1 : 1'b0; sdata_in = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    fmt_sel = later_code;
    cur_req = req; vcount = 0;
    add_half(~left_lvl, 24'h0, m, h);
    for (int f = 0; f < nfr; f++) begin
      logic [23:0] wl, wr;
      wl = 24'($urandom); wr = 24'($urandom);
      if (f == 0) begin wl = 24'h800000; wr = 24'h7FFFFF; end
      if (f == 1) begin wl = 24'h000001; wr = 24'hFFFFFF; end
      add_half(left_lvl, wl, m, h);
      add_half(~left_lvl, wr, m, h);
      exp_l.push_back(expect_of(wl, m));
      exp_r.push_back(expect_of(wr, m));
    end
    add_half(left_lvl, 24'h0, m, 3);
    for (int i = 0; i < lvl_q.size(); i++) begin
      frm_in   = (i2s && i + 1 < lvl_q.size()) ? lvl_q[i+1] : lvl_q[i];
      sdata_in = dat_q[i];
      repeat (4) @(negedge clk);
      bck_in = 1'b1;
      repeat (4) @(negedge clk);
      bck_in = 1'b0;
    end
    repeat (12) @(negedge clk);
    chk({req, "/R10 count"}, 24'(vcount), 24'(nfr));
    exp_l.delete(); exp_r.delete();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 left", left_word, 24'h0);
    chk("R1 right", right_word, 24'h0);
    chk("R1 valid", 24'(frame_valid), 24'h0);
    run_case(3'b010, 3'b010, 32, 4, "R2 lj64");
    run_case(3'b010, 3'b010, 24, 4, "R2 R9 lj48");
    run_case(3'b011, 3'b011, 32, 4, "R3 i2s64");
    run_case(3'b011, 3'b011, 24, 4, "R3 R9 i2s48");
    run_case(3'b100, 3'b100, 32, 4, "R4 rj24_64");
    run_case(3'b100, 3'b100, 24, 4, "R4 R9 rj24_48");
    run_case(3'b001, 3'b001, 32, 4, "R5 rj20_64");
    run_case(3'b001, 3'b001, 20, 4, "R5 R9 rj20_40");
    run_case(3'b000, 3'b000, 32, 4, "R6 rj16_64");
    run_case(3'b000, 3'b000, 16, 4, "R6 R9 rj16_32");
    run_case(3'b101, 3'b101, 32, 3, "R7 code5");
    run_case(3'b110, 3'b110, 24, 3, "R7 code6");
    run_case(3'b111, 3'b111, 32, 3, "R7 code7");
    run_case(3'b010, 3'b000, 32, 3, "R11 late_change");
    run_case(3'b011, 3'b100, 24, 3, "R11 late_change_i2s");
    finish_run();
  end
endmodule